// File: doc/BRIEF.md
# Agree-Mode Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a global history register of recent outcomes. It also keeps a pattern table of 2-bit saturating counters, indexed by the history XORed with low bits of the branch address. The counters do not learn taken or not-taken. They learn whether the branch agrees with a per-branch bias bit. The bias bit sits in a small direct-mapped tagged table and is captured the first time a branch resolves. Because most branches that alias to the same counter follow their own bias, aliasing tends to push the counter the same way instead of in opposite directions.

The fetch stage presents a branch address and reads the prediction in the same cycle. The execute stage reports each resolved branch on the update port: its address, its outcome and a valid strobe. The update is applied at the next clock edge. A prediction made in the same cycle as an update sees the state as it was before that update.

Top module: `agree_predictor`

## Requirements
- R1: After reset the history is zero, every counter holds weakly-agree (binary 10) and every bias entry is invalid, so every prediction is not-taken until the first valid update.
- R2: When the predicted address misses in the bias table (entry invalid or stored tag different), the prediction is not-taken.
- R3: A valid update that misses in the bias table writes the address tag into the entry and sets the bias bit to the actual outcome. Later predictions for that address use this bias bit.
- R4: On a valid update the addressed counter increments when the outcome equals the bias bit and decrements otherwise. It saturates at 0 and 3. A first resolution counts as agreeing.
- R5: On a bias hit the prediction equals the bias bit when the counter's upper bit is 1, and its inverse when the upper bit is 0.
- R6: The counter index is `ghr XOR pc[PC_LSB +: HIST_W]`. The bias slot is `pc[PC_LSB +: BIAS_IDX_W]`, and the tag is the next TAG_W address bits above the slot.
- R7: Each valid update shifts the actual outcome into bit 0 of the history, and older bits move one place up. With upd_valid low, no state changes, whatever the other update inputs carry.
- R8: When predict and update occur in the same cycle, the prediction uses the history, counters and bias entries from before the update.
- R9: A valid update that hits in the bias table leaves the stored bias bit unchanged, even when the outcome differs.
- R10: An update whose tag differs from the resident entry in the same slot replaces that entry. The displaced branch then misses and predicts not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Combinational taken prediction for pred_pc |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A corrupted history register shows at the ports on the very next prediction, because every index moves with it. This is why the stimulus walks the history through every bit position and back to zero. A wrong counter step or a missed saturation stays hidden until the same address is predicted again with the same history. The sequences therefore steer the history back to the trained index and read the counter through the sign of the prediction. A bias bit that is overwritten, or a tag compare that fails, appears as a wrong direction or a spurious not-taken on the first prediction after the faulty update.

// File: rtl/agree_predictor.sv
module agree_predictor #(
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2,
  parameter int HIST_W     = 10,
  parameter int BIAS_IDX_W = 6,
  parameter int TAG_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int PHT_N  = 1 << HIST_W;
  localparam int BIAS_N = 1 << BIAS_IDX_W;
  localparam int TAG_LO = PC_LSB + BIAS_IDX_W;

  logic [HIST_W-1:0]         ghr;
  logic [PHT_N-1:0][1:0]     pht;
  logic [BIAS_N-1:0]         bias_vld;
  logic [BIAS_N-1:0]         bias_dir;
  logic [TAG_W-1:0]          bias_tag [BIAS_N];

  logic [HIST_W-1:0]     pred_idx, upd_idx;
  logic [BIAS_IDX_W-1:0] pred_bidx, upd_bidx;
  logic [TAG_W-1:0]      pred_tag, upd_tag;
  logic                  pred_hit, pred_bias, pred_agree;
  logic                  upd_hit, upd_bias, upd_agree;
  logic [1:0]            upd_ctr, ctr_next;
  logic                  unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc, upd_pc};

  assign pred_idx  = ghr ^ pred_pc[PC_LSB +: HIST_W];
  assign pred_bidx = pred_pc[PC_LSB +: BIAS_IDX_W];
  assign pred_tag  = pred_pc[TAG_LO +: TAG_W];
  assign pred_hit  = bias_vld[pred_bidx] && (bias_tag[pred_bidx] == pred_tag);
  assign pred_bias = pred_hit && bias_dir[pred_bidx];
  assign pred_agree = pred_hit ? pht[pred_idx][1] : 1'b1;
  assign pred_taken = pred_agree ? pred_bias : ~pred_bias;

  assign upd_idx   = ghr ^ upd_pc[PC_LSB +: HIST_W];
  assign upd_bidx  = upd_pc[PC_LSB +: BIAS_IDX_W];
  assign upd_tag   = upd_pc[TAG_LO +: TAG_W];
  assign upd_hit   = bias_vld[upd_bidx] && (bias_tag[upd_bidx] == upd_tag);
  assign upd_bias  = upd_hit ? bias_dir[upd_bidx] : upd_taken;
  assign upd_agree = (upd_taken == upd_bias);
  assign upd_ctr   = pht[upd_idx];

  always_comb begin
    if (upd_agree) ctr_next = (upd_ctr == 2'b11) ? upd_ctr : upd_ctr + 2'd1;
    else           ctr_next = (upd_ctr == 2'b00) ? upd_ctr : upd_ctr - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr      <= '0;
      bias_vld <= '0;
      for (int i = 0; i < PHT_N; i++) pht[i] <= 2'b10;
    end else if (upd_valid) begin
      ghr           <= {ghr[HIST_W-2:0], upd_taken};
      pht[upd_idx]  <= ctr_next;
      if (!upd_hit) bias_vld[upd_bidx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && !upd_hit) begin
      bias_dir[upd_bidx] <= upd_taken;
      bias_tag[upd_bidx] <= upd_tag;
    end
  end
endmodule

// File: rtl/agree_predictor_chk.sv
module agree_predictor_chk #(
  parameter int HIST_W     = 10,
  parameter int BIAS_IDX_W = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          upd_valid,
  input logic                          upd_taken,
  input logic                          pred_taken,
  input logic [HIST_W-1:0]             ghr,
  input logic [HIST_W-1:0]             upd_idx,
  input logic [BIAS_IDX_W-1:0]         upd_bidx,
  input logic                          upd_hit,
  input logic                          upd_bias,
  input logic                          upd_agree,
  input logic [1:0]                    upd_ctr,
  input logic [(1<<HIST_W)-1:0][1:0]   pht,
  input logic [(1<<BIAS_IDX_W)-1:0]    bias_dir
);
  logic seen_upd;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_upd <= 1'b0;
    else if (upd_valid) seen_upd <= 1'b1;
  end

  // R1
  reset_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_upd |-> !pred_taken);

  // R7
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(upd_taken)});

  // R7
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));

  // R4
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_agree && upd_ctr != 2'b11 |=> pht[$past(upd_idx)] == $past(upd_ctr) + 2'd1);

  // R4
  ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_agree && upd_ctr == 2'b11 |=> pht[$past(upd_idx)] == 2'b11);

  // R4
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_agree && upd_ctr != 2'b00 |=> pht[$past(upd_idx)] == $past(upd_ctr) - 2'd1);

  // R4
  ctr_bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_agree && upd_ctr == 2'b00 |=> pht[$past(upd_idx)] == 2'b00);

  // R3
  bias_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_hit |=> bias_dir[$past(upd_bidx)] == $past(upd_taken));

  // R9
  bias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_hit |=> bias_dir[$past(upd_bidx)] == $past(upd_bias));
endmodule

bind agree_predictor agree_predictor_chk #(.HIST_W(HIST_W), .BIAS_IDX_W(BIAS_IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .pred_taken(pred_taken), .ghr(ghr), .upd_idx(upd_idx), .upd_bidx(upd_bidx),
  .upd_hit(upd_hit), .upd_bias(upd_bias), .upd_agree(upd_agree),
  .upd_ctr(upd_ctr), .pht(pht), .bias_dir(bias_dir)
);

// File: tb/test_agree_predictor.sv
module test_agree_predictor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pred_pc = '0;
  logic       pred_taken;
  logic       upd_valid = 1'b0;
  logic [7:0] upd_pc = '0;
  logic       upd_taken = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  agree_predictor #(.PC_W(8), .PC_LSB(2), .HIST_W(4), .BIAS_IDX_W(2), .TAG_W(4)) i_agree_predictor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // Word address = pc>>2, slot = bits 1:0 of it, tag = bits 5:2, counter index = history ^ bits 3:0.
  // A=0x14 (slot1 tag1 idx5), B=0x18 (slot2 tag1 idx6), D=0x24 (slot1 tag2 idx9).
  // Vector: {rst,upd_valid,upd_taken,expected}{req}{upd_pc}{pred_pc}
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    24'hA1_24_14, // R1 after reset, junk update inputs idle
    24'h68_14_14, // R8 first resolution taken, same-cycle prediction still misses
    24'h33_24_14, // R3 bias learnt, history 1
    24'h55_14_14, // R5 disagree step at history 1
    24'h57_14_14, // R7 history 2
    24'h57_14_14, // R7 history 4
    24'h56_14_14, // R6 history 8, then back to 0
    24'h39_24_14, // R9 bias survives disagreeing outcomes
    24'h58_14_14, // R8
    24'h54_14_14, // R4 counter 10 -> 01
    24'h25_24_14, // R5 counter below half gives inverse of bias
    24'h44_14_14, // R4 -> 00
    24'h44_14_14, // R4 saturate at 00
    24'h64_14_14, // R4 no wrap to 11
    24'h26_24_14, // R6 history 1 selects another counter
    24'hE2_14_18, // R2 after reset, B unknown
    24'h53_18_14, // R3 B learns not-taken bias
    24'h43_18_18, // R3
    24'h47_18_18, // R7
    24'h47_18_18, // R7
    24'h44_18_18, // R4
    24'h44_18_18, // R4 saturate at 11
    24'h44_14_18, // R4 no wrap to 00
    24'h58_14_14, // R8
    24'h25_24_14, // R5
    24'h64_18_14, // R4 B disagree, history 1
    24'h36_24_14, // R6 history selects trained counter
    24'h27_24_18, // R7 idle update left history alone
    24'h7A_24_14, // R10 D evicts A from slot 1
    24'h2A_24_14, // R10 A now misses
    24'h33_24_24  // R3 D predicts from its own bias
  };

  task automatic check(input bit got, input bit exp, input int req, input int id);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d step %0d: pred_taken=%0b expected %0b", req, id, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][23]) do_reset();
      else @(negedge clk);
      upd_valid = VEC[v][22];
      upd_taken = VEC[v][21];
      upd_pc    = VEC[v][15:8];
      pred_pc   = VEC[v][7:0];
      #1;
      check(pred_taken, VEC[v][20], int'(VEC[v][19:16]), v);
    end
    @(negedge clk);
    upd_valid = 1'b0;
    // R5 before reset: B slot hit, history 3 -> counter index 5 holds 01, bias 0 -> taken
    pred_pc = 8'h18;
    #1;
    check(pred_taken, 1'b1, 5, 100);
    do_reset();
    // R1 reset clears trained bias entries
    pred_pc = 8'h18;
    #1;
    check(pred_taken, 1'b0, 1, 101);
    pred_pc = 8'h24;
    #1;
    check(pred_taken, 1'b0, 1, 102);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule